// File: doc/BRIEF.md
# Target Address Match and Acknowledge Decision

This block sits beside the bit engine of an I2C target. Each time a byte has been shifted in, the bit engine presents the byte together with a phase code. The phase code says whether the byte is the first byte after a start, the second byte of an extended (10-bit) address, or a data byte. The engine also presents the current role and transfer direction. One clock later the block returns its verdict. The verdict says whether the byte addressed this target, which address slot matched, whether it was a general call, whether the engine must pull SDA low in the following acknowledge slot, and whether a byte being transmitted is the final one.

Matching runs in parallel over a set of short (7-bit) address slots and one extended 10-bit address. Each slot has a per-bit don't-care mask and a general-call enable, and so does the extended address. Two enables switch short and extended matching on and off as groups. A global acknowledge enable governs every acknowledge the block can request.

Top module: `tgt_addr_ack`

## Requirements
- R1: While rst_n is low, and after reset until the first result, res_vld, hit, hit_idx, gcall, ack, last_tx and the extended-header armed state are all 0.
- R2: A byte presented with byte_vld high in cycle n gives its results on the outputs after the clock edge that ends cycle n. res_vld is high for exactly that one cycle. The other outputs hold until the next result.
- R3: Slot i uses slot_addr[8i+7:8i+1] as its address, slot_addr[8i] as its general-call enable, and slot_mask[7i+6:7i] as its mask. A mask bit of 1 makes that address bit don't care. For a first-phase byte (addr_phase=01) that is neither 0x00 nor of the form 11110xxx, slot i matches when en7=1 and ((rx_byte[7:1] ^ address) & ~mask) == 0. rx_byte[0] (R/W) plays no part.
- R4: When several short slots match, hit=1 and hit_idx gives the lowest matching slot number.
- R5: A first-phase byte of 0x00 is a general call. gcall=1 when some slot has en7=1 and its enable set, or when en10=1 and ext_addr[0]=1. hit_idx is the lowest such slot, or NSLOT if only the extended enable applies. A general call never sets hit.
- R6: A first-phase byte 11110 a9 a8 rw matches the extended header when en10=1 and the pair {a9,a8} agrees with ext_addr[10:9] outside the mask bits ext_mask[9:8]. The match arms the block for a second byte. Any other first-phase byte disarms it. A header alone never sets hit.
- R7: A second-phase byte (addr_phase=10) sets hit=1 and hit_idx=NSLOT only when the block is armed, en10=1, and the byte agrees with ext_addr[8:1] outside the mask bits ext_mask[7:0].
- R8: For an address-phase byte, ack = ack_en AND (slot hit, general call, header match or second-byte hit). With ack_en=0, no acknowledge is requested, although hit and gcall are still reported.
- R9: For a data byte (addr_phase 00 or 11), ack = ack_en AND NOT dir_tx in both roles. hit and gcall are 0.
- R10: last_tx=1 exactly for a data byte with role_ctrl=0, dir_tx=1 and ack_en=0. This marks the transmitted byte as final, and a NACK is then expected.
- R11: With role_ctrl=1, address-phase bytes produce no hit, no gcall and no ack, and they disarm the header.
- R12: en7=0 removes every short slot and its general-call enable from matching. en10=0 removes the header, the second byte and the extended general-call enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A received byte is presented this cycle |
| rx_byte | input | 8 | Received byte, R/W in bit 0 for first bytes |
| addr_phase | input | 2 | 00 data, 01 first byte, 10 second extended byte, 11 data |
| role_ctrl | input | 1 | 1 when acting as bus controller |
| dir_tx | input | 1 | 1 when this side transmits data |
| en7 | input | 1 | Short address matching enable |
| en10 | input | 1 | Extended address matching enable |
| ack_en | input | 1 | Global acknowledge enable |
| slot_addr | input | NSLOT*8 | Per slot: address [7:1], general-call enable [0] |
| slot_mask | input | NSLOT*7 | Per slot: 7-bit don't-care mask |
| ext_addr | input | 11 | Extended address [10:1], general-call enable [0] |
| ext_mask | input | 10 | Extended address don't-care mask |
| res_vld | output | 1 | One-cycle pulse: results below are fresh |
| hit | output | 1 | Own address matched |
| hit_idx | output | $clog2(NSLOT+1) | Matching slot, NSLOT for extended |
| gcall | output | 1 | General call accepted |
| ack | output | 1 | Drive SDA low in the acknowledge slot |
| last_tx | output | 1 | Transmitted byte is the final one |

## Verification
The checker watches the fixed timing on every cycle: the one-cycle result pulse, the data-phase acknowledge rule, the last-byte flag and its exclusion of ack, the silence in controller role, the blocking of ack by a cleared enable, the exclusion of hit and gcall, and the rule that a second byte never hits unarmed. Only the bench's scenarios can show the address arithmetic. That covers masked matches against random slot contents, lowest-slot priority when masks overlap, general-call routing to the right slot or to the extended entry, and the arm-then-match sequence across two bytes, all compared against an independent model.

// File: rtl/tgt_ack_pkg.sv
package tgt_ack_pkg;

  localparam int SHORT_W = 7;
  localparam int EXT_W   = 10;

  localparam logic [1:0] PH_DATA   = 2'b00;
  localparam logic [1:0] PH_FIRST  = 2'b01;
  localparam logic [1:0] PH_SECOND = 2'b10;

  localparam logic [4:0] HDR_TAG = 5'b11110;

  // masked equality: a set mask bit removes that bit from the compare
  function automatic logic short_eq(input logic [SHORT_W-1:0] got,
                                    input logic [SHORT_W-1:0] want,
                                    input logic [SHORT_W-1:0] dc);
    return ((got ^ want) & ~dc) == '0;
  endfunction

  function automatic logic pair_eq(input logic [1:0] got,
                                   input logic [1:0] want,
                                   input logic [1:0] dc);
    return ((got ^ want) & ~dc) == '0;
  endfunction

  function automatic logic octet_eq(input logic [7:0] got,
                                    input logic [7:0] want,
                                    input logic [7:0] dc);
    return ((got ^ want) & ~dc) == '0;
  endfunction

  function automatic logic is_gcall(input logic [7:0] b);
    return b == 8'h00;
  endfunction

  function automatic logic is_header(input logic [7:0] b);
    return b[7:3] == HDR_TAG;
  endfunction

endpackage

// File: rtl/tgt_slot_cmp.sv
module tgt_slot_cmp
  import tgt_ack_pkg::*;
(
  input  logic [SHORT_W-1:0] rx_hi,
  input  logic [7:0]         lane_cfg,
  input  logic [SHORT_W-1:0] lane_mask,
  output logic               addr_hit,
  output logic               gc_en
);
  assign addr_hit = short_eq(rx_hi, lane_cfg[7:1], lane_mask);
  assign gc_en    = lane_cfg[0];
endmodule

// File: rtl/tgt_ext_cmp.sv
module tgt_ext_cmp
  import tgt_ack_pkg::*;
(
  input  logic [7:0]       rx_byte,
  input  logic [EXT_W:0]   ext_cfg,
  input  logic [EXT_W-1:0] ext_dc,
  output logic             hdr_hit,
  output logic             low_hit,
  output logic             gc_en
);
  // upper two address bits ride in the header byte, lower eight in the next one
  assign hdr_hit = pair_eq(rx_byte[2:1], ext_cfg[10:9], ext_dc[9:8]);
  assign low_hit = octet_eq(rx_byte, ext_cfg[8:1], ext_dc[7:0]);
  assign gc_en   = ext_cfg[0];
endmodule

// File: rtl/tgt_ack_decide.sv
module tgt_ack_decide
  import tgt_ack_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int IDXW  = 3
) (
  input  logic [7:0]       rx_byte,
  input  logic [1:0]       addr_phase,
  input  logic             role_ctrl,
  input  logic             dir_tx,
  input  logic             en7,
  input  logic             en10,
  input  logic             ack_en,
  input  logic             armed,
  input  logic [NSLOT-1:0] slot_hit,
  input  logic [NSLOT-1:0] slot_gc,
  input  logic             hdr_hit,
  input  logic             low_hit,
  input  logic             ext_gc,
  output logic             nxt_hit,
  output logic [IDXW-1:0]  nxt_idx,
  output logic             nxt_gc,
  output logic             nxt_ack,
  output logic             nxt_last,
  output logic             hdr_ok
);
  logic [NSLOT:0]    gc_cand;
  logic [NSLOT-1:0]  hit_cand;
  logic [IDXW-1:0]   gc_idx, hit_idx;
  logic              is_first, is_second, is_data, tgt;

  assign gc_cand  = {en10 & ext_gc, slot_gc & {NSLOT{en7}}};
  assign hit_cand = slot_hit & {NSLOT{en7}};

  assign is_first  = addr_phase == PH_FIRST;
  assign is_second = addr_phase == PH_SECOND;
  assign is_data   = !is_first && !is_second;
  assign tgt       = !role_ctrl;

  // lowest index wins: scan downward so the last assignment is the smallest
  always_comb begin
    gc_idx = '0;
    for (int i = NSLOT; i >= 0; i--)
      if (gc_cand[i]) gc_idx = IDXW'(i);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (hit_cand[i]) hit_idx = IDXW'(i);
  end

  always_comb begin
    nxt_hit  = 1'b0;
    nxt_idx  = '0;
    nxt_gc   = 1'b0;
    nxt_ack  = 1'b0;
    nxt_last = 1'b0;
    hdr_ok   = 1'b0;
    if (is_data) begin
      nxt_ack  = ack_en && !dir_tx;
      nxt_last = tgt && dir_tx && !ack_en;
    end else if (tgt && is_first) begin
      if (is_gcall(rx_byte)) begin
        nxt_gc  = |gc_cand;
        nxt_idx = gc_idx;
      end else if (is_header(rx_byte)) begin
        hdr_ok = en10 && hdr_hit;
      end else begin
        nxt_hit = |hit_cand;
        nxt_idx = hit_idx;
      end
      nxt_ack = ack_en && (nxt_hit || nxt_gc || hdr_ok);
    end else if (tgt && is_second) begin
      nxt_hit = armed && en10 && low_hit;
      nxt_idx = nxt_hit ? IDXW'(NSLOT) : '0;
      nxt_ack = ack_en && nxt_hit;
    end
  end
endmodule

// File: rtl/tgt_addr_ack.sv
module tgt_addr_ack
  import tgt_ack_pkg::*;
#(
  parameter  int NSLOT = 4,
  localparam int IDXW  = $clog2(NSLOT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_vld,
  input  logic [7:0]             rx_byte,
  input  logic [1:0]             addr_phase,
  input  logic                   role_ctrl,
  input  logic                   dir_tx,
  input  logic                   en7,
  input  logic                   en10,
  input  logic                   ack_en,
  input  logic [NSLOT*8-1:0]     slot_addr,
  input  logic [NSLOT*SHORT_W-1:0] slot_mask,
  input  logic [EXT_W:0]         ext_addr,
  input  logic [EXT_W-1:0]       ext_mask,
  output logic                   res_vld,
  output logic                   hit,
  output logic [IDXW-1:0]        hit_idx,
  output logic                   gcall,
  output logic                   ack,
  output logic                   last_tx
);
  // named internal events, visible to the bound checker
  logic [NSLOT-1:0] slot_hit_w, slot_gc_w;
  logic             hdr_hit_w, low_hit_w, ext_gc_w, hdr_ok_w;
  logic             armed_q;
  logic             nxt_hit, nxt_gc, nxt_ack, nxt_last;
  logic [IDXW-1:0]  nxt_idx;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    tgt_slot_cmp u_cmp (
      .rx_hi     (rx_byte[7:1]),
      .lane_cfg  (slot_addr[s*8 +: 8]),
      .lane_mask (slot_mask[s*SHORT_W +: SHORT_W]),
      .addr_hit  (slot_hit_w[s]),
      .gc_en     (slot_gc_w[s])
    );
  end

  tgt_ext_cmp u_ext (
    .rx_byte (rx_byte),
    .ext_cfg (ext_addr),
    .ext_dc  (ext_mask),
    .hdr_hit (hdr_hit_w),
    .low_hit (low_hit_w),
    .gc_en   (ext_gc_w)
  );

  tgt_ack_decide #(.NSLOT(NSLOT), .IDXW(IDXW)) u_dec (
    .rx_byte    (rx_byte),
    .addr_phase (addr_phase),
    .role_ctrl  (role_ctrl),
    .dir_tx     (dir_tx),
    .en7        (en7),
    .en10       (en10),
    .ack_en     (ack_en),
    .armed      (armed_q),
    .slot_hit   (slot_hit_w),
    .slot_gc    (slot_gc_w),
    .hdr_hit    (hdr_hit_w),
    .low_hit    (low_hit_w),
    .ext_gc     (ext_gc_w),
    .nxt_hit    (nxt_hit),
    .nxt_idx    (nxt_idx),
    .nxt_gc     (nxt_gc),
    .nxt_ack    (nxt_ack),
    .nxt_last   (nxt_last),
    .hdr_ok     (hdr_ok_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      hit     <= 1'b0;
      hit_idx <= '0;
      gcall   <= 1'b0;
      ack     <= 1'b0;
      last_tx <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      res_vld <= byte_vld;
      if (byte_vld) begin
        hit     <= nxt_hit;
        hit_idx <= nxt_idx;
        gcall   <= nxt_gc;
        ack     <= nxt_ack;
        last_tx <= nxt_last;
        if (addr_phase == PH_FIRST) armed_q <= hdr_ok_w;
      end
    end
  end
endmodule

// File: rtl/tgt_ack_chk.sv
module tgt_ack_chk
  import tgt_ack_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int IDXW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            byte_vld,
  input logic [1:0]      addr_phase,
  input logic            role_ctrl,
  input logic            dir_tx,
  input logic            ack_en,
  input logic            armed_q,
  input logic            res_vld,
  input logic            hit,
  input logic [IDXW-1:0] hit_idx,
  input logic            gcall,
  input logic            ack,
  input logic            last_tx
);
  logic data_ph;
  assign data_ph = addr_phase != PH_FIRST && addr_phase != PH_SECOND;

  // R2
  res_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(byte_vld));
  // R2
  byte_gives_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> res_vld);
  // R9
  data_ack_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && data_ph |=> ack == $past(ack_en && !dir_tx));
  // R9
  data_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && data_ph |=> !hit && !gcall);
  // R10
  last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && data_ph && !role_ctrl && dir_tx && !ack_en |=> last_tx);
  // R10
  last_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_tx |-> !ack);
  // R8
  ack_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && !ack_en |=> !ack);
  // R11
  ctrl_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && role_ctrl && !data_ph |=> !hit && !gcall && !ack);
  // R5
  gc_hit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && gcall));
  // R7
  unarmed_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && addr_phase == PH_SECOND && !armed_q |=> !hit);
  // R7
  second_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && addr_phase == PH_SECOND |=> !hit || hit_idx == IDXW'(NSLOT));
endmodule

bind tgt_addr_ack tgt_ack_chk #(.NSLOT(NSLOT), .IDXW(IDXW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_vld   (byte_vld),
  .addr_phase (addr_phase),
  .role_ctrl  (role_ctrl),
  .dir_tx     (dir_tx),
  .ack_en     (ack_en),
  .armed_q    (armed_q),
  .res_vld    (res_vld),
  .hit        (hit),
  .hit_idx    (hit_idx),
  .gcall      (gcall),
  .ack        (ack),
  .last_tx    (last_tx)
);

// File: tb/sim_tgt_addr_ack.sv
module sim_tgt_addr_ack;
  localparam int NS = 4;
  localparam int IW = $clog2(NS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [1:0] addr_phase = '0;
  logic role_ctrl = 1'b0, dir_tx = 1'b0, en7 = 1'b0, en10 = 1'b0, ack_en = 1'b0;
  logic [NS*8-1:0] slot_addr = '0;
  logic [NS*7-1:0] slot_mask = '0;
  logic [10:0] ext_addr = '0;
  logic [9:0]  ext_mask = '0;
  logic res_vld, hit, gcall, ack, last_tx;
  logic [IW-1:0] hit_idx;

  int checks = 0, fails = 0;
  bit m_armed = 0;
  bit e_hit, e_gc, e_ack, e_last, e_arm;
  int e_idx;
  string e_tag;

  always #4 clk = ~clk;

  tgt_addr_ack #(.NSLOT(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .rx_byte(rx_byte),
    .addr_phase(addr_phase), .role_ctrl(role_ctrl), .dir_tx(dir_tx),
    .en7(en7), .en10(en10), .ack_en(ack_en), .slot_addr(slot_addr),
    .slot_mask(slot_mask), .ext_addr(ext_addr), .ext_mask(ext_mask),
    .res_vld(res_vld), .hit(hit), .hit_idx(hit_idx), .gcall(gcall),
    .ack(ack), .last_tx(last_tx)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // bitwise compare loop, written independently of the design arithmetic
  function automatic bit bits_agree(input int got, input int want, input int dc, input int n);
    for (int b = 0; b < n; b++)
      if (!dc[b] && (got[b] != want[b])) return 0;
    return 1;
  endfunction

  task automatic model();
    bit first, second, tgt;
    first  = addr_phase == 2'b01;
    second = addr_phase == 2'b10;
    tgt    = !role_ctrl;
    e_hit = 0; e_gc = 0; e_ack = 0; e_last = 0; e_idx = 0; e_arm = m_armed;
    if (!first && !second) begin
      e_tag  = "R9/R10";
      e_ack  = ack_en && !dir_tx;
      e_last = tgt && dir_tx && !ack_en;
    end else if (!tgt) begin
      e_tag = "R11";
      if (first) e_arm = 0;
    end else if (first) begin
      e_arm = 0;
      if (rx_byte == 8'h00) begin
        e_tag = "R5/R12";
        for (int i = 0; i < NS && !e_gc; i++)
          if (en7 && slot_addr[i*8]) begin e_gc = 1; e_idx = i; end
        if (!e_gc && en10 && ext_addr[0]) begin e_gc = 1; e_idx = NS; end
        e_ack = ack_en && e_gc;
      end else if (rx_byte[7:3] == 5'b11110) begin
        e_tag = "R6/R12";
        e_arm = en10 && bits_agree(int'(rx_byte[2:1]), int'(ext_addr[10:9]), int'(ext_mask[9:8]), 2);
        e_ack = ack_en && e_arm;
      end else begin
        e_tag = "R3/R4/R12";
        for (int i = 0; i < NS && !e_hit; i++)
          if (en7 && bits_agree(int'(rx_byte[7:1]), int'(slot_addr[i*8+1 +: 7]), int'(slot_mask[i*7 +: 7]), 7)) begin
            e_hit = 1; e_idx = i;
          end
        e_ack = ack_en && e_hit;
      end
    end else begin
      e_tag = "R7";
      e_hit = m_armed && en10 && bits_agree(int'(rx_byte), int'(ext_addr[8:1]), int'(ext_mask[7:0]), 8);
      e_idx = e_hit ? NS : 0;
      e_ack = ack_en && e_hit;
    end
  endtask

  // called at a negedge: present one byte, check the registered result one edge later
  task automatic send(input logic [7:0] b, input logic [1:0] ph);
    rx_byte = b; addr_phase = ph; byte_vld = 1'b1;
    model();
    @(negedge clk);
    byte_vld = 1'b0;
    chk(res_vld, 1, "R2 res_vld");
    chk(hit, e_hit, {e_tag, " hit"});
    chk(hit_idx, e_idx, {e_tag, " hit_idx"});
    chk(gcall, e_gc, {e_tag, " gcall"});
    chk(ack, e_ack, {e_tag, " R8 ack"});
    chk(last_tx, e_last, {e_tag, " last_tx"});
    m_armed = e_arm;
  endtask

  task automatic set_slot(input int i, input logic [6:0] a, input logic gc, input logic [6:0] m);
    slot_addr[i*8 +: 8] = {a, gc};
    slot_mask[i*7 +: 7] = m;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(res_vld, 0, "R1 res_vld"); chk(hit, 0, "R1 hit"); chk(gcall, 0, "R1 gcall");
    chk(ack, 0, "R1 ack"); chk(last_tx, 0, "R1 last_tx"); chk(hit_idx, 0, "R1 hit_idx");
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_vld, 0, "R1 res_vld after release");

    // directed: overlapping slots, lowest wins (R4)
    en7 = 1; en10 = 1; ack_en = 1;
    set_slot(0, 7'h20, 0, 7'h00);
    set_slot(1, 7'h34, 0, 7'h03);
    set_slot(2, 7'h35, 1, 7'h00);
    set_slot(3, 7'h30, 0, 7'h0F);
    ext_addr = {10'h2A5, 1'b0}; ext_mask = '0;
    send({7'h35, 1'b0}, 2'b01);           // R4: slots 1,2,3 all match, expect 1
    chk(hit_idx, 1, "R4 lowest slot");
    @(negedge clk);
    chk(res_vld, 0, "R2 single pulse");
    send({7'h20, 1'b1}, 2'b01);           // R3 exact match slot 0, read bit ignored
    send({7'h21, 1'b0}, 2'b01);           // R3 miss on unmasked bit
    send(8'h00, 2'b01);                   // R5 general call to slot 2
    chk(hit_idx, 2, "R5 gc slot");
    // R10 last byte and R9 data rules
    send(8'hA5, 2'b00);
    dir_tx = 1; ack_en = 0;
    send(8'h11, 2'b00);
    chk(last_tx, 1, "R10 last byte");
    dir_tx = 0;
    send({7'h20, 1'b0}, 2'b01);           // R8 hit without ack
    ack_en = 1;
    // R6/R7 extended sequence: header 11110 10 0 then low 0xA5
    send(8'b1111_0100, 2'b01);
    send(8'hA5, 2'b10);
    chk(hit_idx, NS, "R7 ext index");
    send(8'b1111_0110, 2'b01);            // wrong upper bits, disarm
    send(8'hA5, 2'b10);
    chk(hit, 0, "R7 unarmed second");
    // R11 controller role
    role_ctrl = 1;
    send({7'h20, 1'b0}, 2'b01);
    role_ctrl = 0;
    // R12 enables off
    en7 = 0;
    send({7'h20, 1'b0}, 2'b01);
    send(8'h00, 2'b01);
    ext_addr[0] = 1'b1;
    send(8'h00, 2'b01);                   // R5 extended general call only
    en10 = 0;
    send(8'b1111_0100, 2'b01);
    en7 = 1; en10 = 1;

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int sel;
      if (n % 50 == 0) begin
        slot_addr = $urandom; slot_mask = $urandom & 28'h0492492;
        ext_addr = 11'($urandom); ext_mask = 10'($urandom) & 10'h155;
      end
      en7 = ($urandom % 8) != 0; en10 = ($urandom % 8) != 0;
      ack_en = ($urandom % 4) != 0; dir_tx = $urandom % 2;
      role_ctrl = ($urandom % 6) == 0;
      sel = $urandom % 10;
      if (sel < 3)       send({slot_addr[($urandom % NS)*8 + 1 +: 7], 1'($urandom)}, 2'b01);
      else if (sel == 3) send(8'h00, 2'b01);
      else if (sel == 4) send({5'b11110, ext_addr[10:9], 1'($urandom)}, 2'b01);
      else if (sel == 5) send(ext_addr[8:1], 2'b10);
      else if (sel == 6) send(8'($urandom), 2'b10);
      else               send(8'($urandom), 2'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule